// File: doc/BRIEF.md
# NAND Flash Command Sequencer

This block drives a raw 8-bit NAND flash bus on behalf of a controller. It handles up to four chips, and each chip has its own chip-enable line. A single request names an operation, a bank, a page and a flag that selects the spare area. The sequencer then runs the whole bus conversation for that operation. It issues the command cycles and the address cycles. It moves payload bytes through a write byte stream (valid/ready) and a read byte stream (one-cycle valid). For page read, program and erase it polls the chip's status byte until the chip is ready, then puts the chip back in read mode. Each operation ends with a one-cycle `done` pulse, or with `err` (plus `tout` when a wait ran out of time).

Each bank has two stored timing values: the strobe-low width and the strobe-high hold. Both default to 7 after reset and can be rewritten at any time through a small configuration port. Waits on ready/busy and on status polling are bounded by a cycle budget. That budget is derived from the clock frequency and a timeout in milliseconds.

Top module: `nfc_sequencer`

## Requirements
- R1: After reset the block is idle. `busy`, `done`, `err` and `tout` are low, every `nf_ce` bit is low, and both `nf_we_n` and `nf_re_n` are high.
- R2: During an operation exactly one `nf_ce` bit is high: bit `req_bank`. It stays unchanged until the cycle after `done` or `err`. A request made while busy is ignored. Op codes 5 to 7 end at once with `err`, with no bus cycle.
- R3: Op code 0 (reset) sends command 0xFF. It then waits for `nf_rb[bank]` to be high before `done`.
- R4: Op code 1 (read ID) sends command 0x90 and one address byte 0x00. It then reads four bytes and packs them into `id_word`, with the first byte in bits 7:0.
- R5: Op code 2 (page read) sends 0x00, then five address bytes in this order: column low, column high, page[7:0], page[15:8], page[23:16]. It then sends 0x30 and polls status. After the poll it delivers `req_cnt`+1 bytes on the read stream.
- R6: The column is 0x0800 when `req_spare` is 1 and 0x0000 otherwise.
- R7: A status poll sends 0x70 and reads status bytes until one has bit 6 set. It then sends 0x00, and no further status reads follow.
- R8: Op code 3 (program) sends 0x80 and the five address bytes. It then writes `req_cnt`+1 bytes taken from the write stream and sends 0x10. It polls status only when `req_poll` is 1.
- R9: Op code 4 (erase) sends 0x60 and three row bytes (page[7:0], page[15:8], page[23:16]), with no column bytes. It then sends 0xD0 and polls status.
- R10: If a ready wait or a status poll lasts longer than the timeout budget, the operation ends with `err` and `tout` together, and `done` stays low.
- R11: Every bus strobe stays low for pulse+1 cycles of the selected bank. Each bank's pulse and hold reset to 7 and are written through the `tcfg_*` port.
- R12: `nf_cle` is high during command cycles and `nf_ale` during address cycles, never both together. `nf_dq_oe` is low whenever `nf_re_n` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | Request strobe, taken when idle |
| req_op | input | 3 | Operation code |
| req_bank | input | BANK_W | Target bank |
| req_page | input | PAGE_W | Page (row) address |
| req_spare | input | 1 | Access spare area only (column 0x800) |
| req_poll | input | 1 | Program: poll status after confirm |
| req_cnt | input | CNT_W | Payload bytes minus one |
| wr_data | input | 8 | Write stream byte |
| wr_valid | input | 1 | Write stream byte available |
| wr_ready | output | 1 | Write stream byte taken |
| rd_data | output | 8 | Read stream byte |
| rd_valid | output | 1 | Read stream byte valid (one cycle) |
| id_word | output | 32 | Packed chip ID |
| busy | output | 1 | Operation in progress |
| done | output | 1 | Operation finished without error |
| err | output | 1 | Operation failed |
| tout | output | 1 | Failure was a timeout |
| tcfg_wr | input | 1 | Timing write strobe |
| tcfg_bank | input | BANK_W | Bank whose timing is written |
| tcfg_pulse | input | TIME_W | Strobe-low width minus one |
| tcfg_hold | input | TIME_W | Strobe-high hold minus one |
| nf_ce | output | NBANK | One-hot chip enables |
| nf_cle | output | 1 | Command latch enable |
| nf_ale | output | 1 | Address latch enable |
| nf_we_n | output | 1 | Write strobe, active low |
| nf_re_n | output | 1 | Read strobe, active low |
| nf_dq_o | output | 8 | Bus data out |
| nf_dq_oe | output | 1 | Bus data output enable |
| nf_dq_i | input | 8 | Bus data in |
| nf_rb | input | NBANK | Per-bank ready (high) / busy |

## Verification
The bench holds the status byte at not-ready for several reads. A sequencer that sampled the status byte at the wrong moment, or never sent the closing 0x00, would show up as a wrong poll count or a missing final command. Ready/busy is held low before the reset operation. An early `done` would expose a design that does not wait on the right bank's line. The tests also pin the lengths of the erase and spare-area addresses, the packing order of the ID, and the no-poll program. A mixed-up column or row byte, or an extra poll, breaks the logged byte sequence. Finally, the bench reprograms one bank's strobe width and sends a request while the block is busy. This catches timing taken from the wrong bank and a second request leaking into a running operation.

// File: rtl/nfc_pkg.sv
package nfc_pkg;
   typedef enum logic [2:0] {
      OP_RESET  = 3'd0,
      OP_READID = 3'd1,
      OP_READ   = 3'd2,
      OP_PROG   = 3'd3,
      OP_ERASE  = 3'd4
   } op_e;

   typedef enum logic [1:0] {
      BK_CMD  = 2'd0,
      BK_ADDR = 2'd1,
      BK_WR   = 2'd2,
      BK_RD   = 2'd3
   } bus_kind_e;

   typedef enum logic [3:0] {
      S_IDLE, S_CMD1, S_ADDR, S_CMD2, S_WAITRB, S_STCMD,
      S_STRD, S_RDMODE, S_XFER, S_DONE, S_FAIL
   } seq_state_e;

   localparam logic [7:0] C_READ0   = 8'h00;
   localparam logic [7:0] C_READGO  = 8'h30;
   localparam logic [7:0] C_PROG    = 8'h80;
   localparam logic [7:0] C_PROGGO  = 8'h10;
   localparam logic [7:0] C_ERASE   = 8'h60;
   localparam logic [7:0] C_ERASEGO = 8'hD0;
   localparam logic [7:0] C_STATUS  = 8'h70;
   localparam logic [7:0] C_IDENT   = 8'h90;
   localparam logic [7:0] C_RESET   = 8'hFF;
   localparam int         RDY_BIT   = 6;
endpackage

// File: rtl/nfc_strobe.sv
module nfc_strobe
   import nfc_pkg::*;
#(
   parameter int TIME_W = 4
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              start,
   input  bus_kind_e         kind,
   input  logic [7:0]        byte_i,
   input  logic [TIME_W-1:0] t_pulse,
   input  logic [TIME_W-1:0] t_hold,
   input  logic [7:0]        dq_i,
   output logic              idle,
   output logic              fin,
   output logic [7:0]        rbyte,
   output logic              cle,
   output logic              ale,
   output logic              we_n,
   output logic              re_n,
   output logic [7:0]        dq_o,
   output logic              dq_oe
);
   typedef enum logic [1:0] {PH_IDLE, PH_LOW, PH_HIGH} phase_e;

   phase_e            ph;
   logic [TIME_W-1:0] cnt;
   bus_kind_e         kind_q;
   logic [7:0]        byte_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         ph     <= PH_IDLE;
         cnt    <= '0;
         kind_q <= BK_CMD;
         byte_q <= '0;
         rbyte  <= '0;
      end else begin
         case (ph)
            PH_IDLE: if (start) begin
               ph     <= PH_LOW;
               cnt    <= t_pulse;
               kind_q <= kind;
               byte_q <= byte_i;
            end
            PH_LOW: if (cnt == '0) begin
               ph  <= PH_HIGH;
               cnt <= t_hold;
               if (kind_q == BK_RD) rbyte <= dq_i;
            end else cnt <= cnt - 1'b1;
            default: if (cnt == '0) ph <= PH_IDLE;
                     else cnt <= cnt - 1'b1;
         endcase
      end
   end

   assign idle  = (ph == PH_IDLE);
   assign fin   = (ph == PH_HIGH) && (cnt == '0);
   assign cle   = !idle && (kind_q == BK_CMD);
   assign ale   = !idle && (kind_q == BK_ADDR);
   assign we_n  = !((ph == PH_LOW) && (kind_q != BK_RD));
   assign re_n  = !((ph == PH_LOW) && (kind_q == BK_RD));
   assign dq_o  = byte_q;
   assign dq_oe = !idle && (kind_q != BK_RD);
endmodule

// File: rtl/nfc_wait_timer.sv
module nfc_wait_timer #(
   parameter int LIMIT = 1000
) (
   input  logic clk,
   input  logic rst_n,
   input  logic run,
   output logic expired
);
   localparam int CW = $clog2(LIMIT + 1);
   localparam logic [CW-1:0] LIM = CW'(LIMIT);

   logic [CW-1:0] cnt;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)               cnt <= '0;
      else if (!run)            cnt <= '0;
      else if (cnt != LIM)      cnt <= cnt + 1'b1;
   end

   assign expired = (cnt == LIM);
endmodule

// File: rtl/nfc_sequencer.sv
module nfc_sequencer
   import nfc_pkg::*;
#(
   parameter int NBANK      = 4,
   parameter int PAGE_W     = 24,
   parameter int CNT_W      = 12,
   parameter int TIME_W     = 4,
   parameter int TIME_DEF   = 7,
   parameter int CLK_HZ     = 50_000_000,
   parameter int TIMEOUT_MS = 20,
   localparam int BANK_W    = (NBANK > 1) ? $clog2(NBANK) : 1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              req_valid,
   input  logic [2:0]        req_op,
   input  logic [BANK_W-1:0] req_bank,
   input  logic [PAGE_W-1:0] req_page,
   input  logic              req_spare,
   input  logic              req_poll,
   input  logic [CNT_W-1:0]  req_cnt,
   input  logic [7:0]        wr_data,
   input  logic              wr_valid,
   output logic              wr_ready,
   output logic [7:0]        rd_data,
   output logic              rd_valid,
   output logic [31:0]       id_word,
   output logic              busy,
   output logic              done,
   output logic              err,
   output logic              tout,
   input  logic              tcfg_wr,
   input  logic [BANK_W-1:0] tcfg_bank,
   input  logic [TIME_W-1:0] tcfg_pulse,
   input  logic [TIME_W-1:0] tcfg_hold,
   output logic [NBANK-1:0]  nf_ce,
   output logic              nf_cle,
   output logic              nf_ale,
   output logic              nf_we_n,
   output logic              nf_re_n,
   output logic [7:0]        nf_dq_o,
   output logic              nf_dq_oe,
   input  logic [7:0]        nf_dq_i,
   input  logic [NBANK-1:0]  nf_rb
);
   localparam int TOUT_CYC = (CLK_HZ / 1000) * TIMEOUT_MS;

   if (NBANK < 1 || NBANK > 8) begin : g_bad_nbank
      $error("nfc_sequencer: NBANK must be 1..8");
   end
   if (PAGE_W < 8 || PAGE_W > 24) begin : g_bad_page
      $error("nfc_sequencer: PAGE_W must be 8..24");
   end
   if (CNT_W < 2 || TIME_W < 1 || TOUT_CYC < 1) begin : g_bad_misc
      $error("nfc_sequencer: CNT_W, TIME_W or timeout out of range");
   end

   // per-bank strobe timing
   logic [TIME_W-1:0] t_pulse [NBANK];
   logic [TIME_W-1:0] t_hold  [NBANK];

   for (genvar g = 0; g < NBANK; g++) begin : g_bank_tim
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) begin
            t_pulse[g] <= TIME_W'(TIME_DEF);
            t_hold[g]  <= TIME_W'(TIME_DEF);
         end else if (tcfg_wr && (tcfg_bank == BANK_W'(g))) begin
            t_pulse[g] <= tcfg_pulse;
            t_hold[g]  <= tcfg_hold;
         end
      end
   end

   seq_state_e        state;
   op_e               op_q;
   logic [BANK_W-1:0] bank_q;
   logic [23:0]       page_q;
   logic              spare_q, poll_q, launched, tout_q;
   logic [CNT_W-1:0]  cnt_q, xcnt;
   logic [2:0]        addr_idx;
   logic [31:0]       id_q;

   logic              bus_req, start, phy_idle, fin, expired;
   bus_kind_e         bus_kind;
   logic [7:0]        bus_byte, rbyte, addr_byte;
   logic [2:0]        addr_last;
   logic [CNT_W-1:0]  xfer_last;

   always_comb begin
      case (addr_idx)
         3'd0:    addr_byte = 8'h00;
         3'd1:    addr_byte = spare_q ? 8'h08 : 8'h00;
         3'd2:    addr_byte = page_q[7:0];
         3'd3:    addr_byte = page_q[15:8];
         default: addr_byte = page_q[23:16];
      endcase
      addr_last = (op_q == OP_READID) ? 3'd0 : 3'd4;
      xfer_last = (op_q == OP_READID) ? CNT_W'(3) : cnt_q;
   end

   always_comb begin
      bus_req  = 1'b0;
      bus_kind = BK_CMD;
      bus_byte = 8'h00;
      case (state)
         S_CMD1: begin
            bus_req = 1'b1;
            case (op_q)
               OP_RESET:  bus_byte = C_RESET;
               OP_READID: bus_byte = C_IDENT;
               OP_PROG:   bus_byte = C_PROG;
               OP_ERASE:  bus_byte = C_ERASE;
               default:   bus_byte = C_READ0;
            endcase
         end
         S_ADDR: begin
            bus_req  = 1'b1;
            bus_kind = BK_ADDR;
            bus_byte = addr_byte;
         end
         S_CMD2: begin
            bus_req  = 1'b1;
            bus_byte = (op_q == OP_READ) ? C_READGO :
                       (op_q == OP_PROG) ? C_PROGGO : C_ERASEGO;
         end
         S_STCMD:  begin bus_req = 1'b1; bus_byte = C_STATUS; end
         S_STRD:   begin bus_req = 1'b1; bus_kind = BK_RD;    end
         S_RDMODE: begin bus_req = 1'b1; bus_byte = C_READ0;  end
         S_XFER: begin
            if (op_q == OP_PROG) begin
               bus_req  = wr_valid;
               bus_kind = BK_WR;
               bus_byte = wr_data;
            end else begin
               bus_req  = 1'b1;
               bus_kind = BK_RD;
            end
         end
         default: ;
      endcase
   end

   assign start    = bus_req && phy_idle && !launched;
   assign wr_ready = (state == S_XFER) && (op_q == OP_PROG) && phy_idle && !launched;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state    <= S_IDLE;
         op_q     <= OP_RESET;
         bank_q   <= '0;
         page_q   <= '0;
         spare_q  <= 1'b0;
         poll_q   <= 1'b0;
         cnt_q    <= '0;
         xcnt     <= '0;
         addr_idx <= '0;
         launched <= 1'b0;
         tout_q   <= 1'b0;
         id_q     <= '0;
      end else begin
         if (start)    launched <= 1'b1;
         else if (fin) launched <= 1'b0;
         case (state)
            S_IDLE: if (req_valid) begin
               op_q     <= op_e'(req_op);
               bank_q   <= req_bank;
               page_q   <= 24'(req_page);
               spare_q  <= req_spare;
               poll_q   <= req_poll;
               cnt_q    <= req_cnt;
               xcnt     <= '0;
               tout_q   <= 1'b0;
               addr_idx <= (req_op == OP_ERASE) ? 3'd2 : 3'd0;
               state    <= (req_op > OP_ERASE || 32'(req_bank) >= NBANK) ? S_FAIL : S_CMD1;
            end
            S_CMD1: if (fin) state <= (op_q == OP_RESET) ? S_WAITRB : S_ADDR;
            S_ADDR: if (fin) begin
               if (addr_idx == addr_last)
                  state <= (op_q == OP_READ || op_q == OP_ERASE) ? S_CMD2 : S_XFER;
               else
                  addr_idx <= addr_idx + 1'b1;
            end
            S_CMD2: if (fin) state <= (op_q == OP_PROG && !poll_q) ? S_DONE : S_STCMD;
            S_WAITRB: begin
               if (nf_rb[bank_q]) state <= S_DONE;
               else if (expired) begin state <= S_FAIL; tout_q <= 1'b1; end
            end
            S_STCMD: if (fin) state <= S_STRD;
            S_STRD: if (fin) begin
               if (rbyte[RDY_BIT]) state <= S_RDMODE;
               else if (expired) begin state <= S_FAIL; tout_q <= 1'b1; end
            end
            S_RDMODE: if (fin) state <= (op_q == OP_READ) ? S_XFER : S_DONE;
            S_XFER: if (fin) begin
               if (op_q == OP_READID) id_q[{xcnt[1:0], 3'b000} +: 8] <= rbyte;
               if (xcnt == xfer_last) state <= (op_q == OP_PROG) ? S_CMD2 : S_DONE;
               else xcnt <= xcnt + 1'b1;
            end
            default: state <= S_IDLE;
         endcase
      end
   end

   nfc_strobe #(.TIME_W(TIME_W)) u_strobe (
      .clk(clk), .rst_n(rst_n), .start(start), .kind(bus_kind), .byte_i(bus_byte),
      .t_pulse(t_pulse[bank_q]), .t_hold(t_hold[bank_q]), .dq_i(nf_dq_i),
      .idle(phy_idle), .fin(fin), .rbyte(rbyte), .cle(nf_cle), .ale(nf_ale),
      .we_n(nf_we_n), .re_n(nf_re_n), .dq_o(nf_dq_o), .dq_oe(nf_dq_oe)
   );

   nfc_wait_timer #(.LIMIT(TOUT_CYC)) u_timer (
      .clk(clk), .rst_n(rst_n),
      .run(state == S_WAITRB || state == S_STCMD || state == S_STRD),
      .expired(expired)
   );

   assign busy     = (state != S_IDLE);
   assign done     = (state == S_DONE);
   assign err      = (state == S_FAIL);
   assign tout     = err && tout_q;
   assign nf_ce    = busy ? (NBANK'(1) << bank_q) : '0;
   assign rd_data  = rbyte;
   assign rd_valid = (state == S_XFER) && fin && (op_q == OP_READ);
   assign id_word  = id_q;
endmodule

// File: rtl/nfc_sequencer_chk.sv
module nfc_sequencer_chk #(
   parameter int NBANK = 4
) (
   input logic             clk,
   input logic             rst_n,
   input logic             busy,
   input logic             done,
   input logic             err,
   input logic             tout,
   input logic [NBANK-1:0] nf_ce,
   input logic             nf_cle,
   input logic             nf_ale,
   input logic             nf_we_n,
   input logic             nf_re_n,
   input logic             nf_dq_oe
);
   p_idle_quiet_r1: assert property (@(posedge clk) disable iff (!rst_n)
      !busy |-> (nf_we_n && nf_re_n && nf_ce == '0));

   p_ce_onehot_r2: assert property (@(posedge clk) disable iff (!rst_n)
      $onehot0(nf_ce));

   p_ce_steady_r2: assert property (@(posedge clk) disable iff (!rst_n)
      (busy && $past(busy)) |-> $stable(nf_ce));

   p_end_idle_r2: assert property (@(posedge clk) disable iff (!rst_n)
      (done || err) |=> !busy);

   p_strobe_ce_r2: assert property (@(posedge clk) disable iff (!rst_n)
      (!nf_we_n || !nf_re_n) |-> (nf_ce != '0));

   p_done_err_excl_r10: assert property (@(posedge clk) disable iff (!rst_n)
      !(done && err));

   p_tout_err_r10: assert property (@(posedge clk) disable iff (!rst_n)
      tout |-> err);

   p_strobe_excl_r11: assert property (@(posedge clk) disable iff (!rst_n)
      !(!nf_we_n && !nf_re_n));

   p_latch_excl_r12: assert property (@(posedge clk) disable iff (!rst_n)
      !(nf_cle && nf_ale));

   p_oe_read_r12: assert property (@(posedge clk) disable iff (!rst_n)
      !nf_re_n |-> !nf_dq_oe);
endmodule

bind nfc_sequencer nfc_sequencer_chk #(.NBANK(NBANK)) u_chk (
   .clk(clk), .rst_n(rst_n), .busy(busy), .done(done), .err(err), .tout(tout),
   .nf_ce(nf_ce), .nf_cle(nf_cle), .nf_ale(nf_ale), .nf_we_n(nf_we_n),
   .nf_re_n(nf_re_n), .nf_dq_oe(nf_dq_oe)
);

// File: tb/nfc_sequencer_tb.sv
module nfc_sequencer_tb;
   logic clk = 1'b0;
   logic rst_n = 1'b0;
   always #10 clk = ~clk;

   logic        req_valid = 0, req_spare = 0, req_poll = 0;
   logic [2:0]  req_op = 0;
   logic [1:0]  req_bank = 0;
   logic [23:0] req_page = 0;
   logic [11:0] req_cnt = 0;
   logic [7:0]  wr_data;
   logic        wr_valid = 1, wr_ready;
   logic [7:0]  rd_data;
   logic        rd_valid, busy, done, err, tout;
   logic [31:0] id_word;
   logic        tcfg_wr = 0;
   logic [1:0]  tcfg_bank = 0;
   logic [3:0]  tcfg_pulse = 0, tcfg_hold = 0;
   logic [3:0]  nf_ce;
   logic        nf_cle, nf_ale, nf_we_n, nf_re_n, nf_dq_oe;
   logic [7:0]  nf_dq_o, nf_dq_i;
   logic [3:0]  nf_rb = 4'hF;

   nfc_sequencer #(.CLK_HZ(50_000), .TIMEOUT_MS(20)) u_dut (
      .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_op(req_op),
      .req_bank(req_bank), .req_page(req_page), .req_spare(req_spare),
      .req_poll(req_poll), .req_cnt(req_cnt), .wr_data(wr_data),
      .wr_valid(wr_valid), .wr_ready(wr_ready), .rd_data(rd_data),
      .rd_valid(rd_valid), .id_word(id_word), .busy(busy), .done(done),
      .err(err), .tout(tout), .tcfg_wr(tcfg_wr), .tcfg_bank(tcfg_bank),
      .tcfg_pulse(tcfg_pulse), .tcfg_hold(tcfg_hold), .nf_ce(nf_ce),
      .nf_cle(nf_cle), .nf_ale(nf_ale), .nf_we_n(nf_we_n), .nf_re_n(nf_re_n),
      .nf_dq_o(nf_dq_o), .nf_dq_oe(nf_dq_oe), .nf_dq_i(nf_dq_i), .nf_rb(nf_rb)
   );

   int errors = 0, checks = 0, cycles = 0;

   // flash model and bus log
   int         nlog = 0, rd_idx = 0, stat_reads = 0, poll_busy = 0;
   bit         poll_forever = 0;
   logic [7:0] last_cmd = 8'h00;
   logic [1:0] logk [64];      // 0 cmd, 1 addr, 2 write data
   logic [7:0] logv [64];
   logic [3:0] logce [64];
   int         lowcnt = 0, lastlow = 0, oe_viol = 0;
   int         wr_idx = 0, nrd = 0;
   logic [7:0] rdbuf [64];

   assign wr_data = 8'hA0 + 8'(wr_idx);

   always_comb begin
      if (last_cmd == 8'h70)
         nf_dq_i = (!poll_forever && stat_reads >= poll_busy) ? 8'h40 : 8'h00;
      else if (last_cmd == 8'h90)
         case (rd_idx)
            0: nf_dq_i = 8'hEC;
            1: nf_dq_i = 8'hD3;
            2: nf_dq_i = 8'h14;
            default: nf_dq_i = 8'hA5;
         endcase
      else nf_dq_i = 8'h30 + 8'(rd_idx);
   end

   always @(posedge nf_we_n) if (rst_n && nlog < 64) begin
      logk[nlog]  = nf_cle ? 2'd0 : nf_ale ? 2'd1 : 2'd2;
      logv[nlog]  = nf_dq_o;
      logce[nlog] = nf_ce;
      nlog++;
      if (nf_cle) begin
         last_cmd = nf_dq_o;
         rd_idx = 0;
         if (nf_dq_o == 8'h70) stat_reads = 0;
      end
   end

   always @(posedge nf_re_n) if (rst_n) begin
      rd_idx++;
      if (last_cmd == 8'h70) stat_reads++;
   end

   always @(posedge clk) begin
      cycles++;
      if (!nf_we_n || !nf_re_n) lowcnt++;
      else if (lowcnt != 0) begin lastlow = lowcnt; lowcnt = 0; end
      if (!nf_re_n && nf_dq_oe) oe_viol++;
      if (wr_valid && wr_ready) wr_idx <= wr_idx + 1;
      if (rd_valid && nrd < 64) begin rdbuf[nrd] <= rd_data; nrd <= nrd + 1; end
      if (cycles > 150000) begin
         $display("FAIL watchdog: act=%0d cycles exp<=150000", cycles);
         errors++;
         $display("Result: errors=%0d of %0d checks", errors, checks + 1);
         $finish;
      end
   end

   task automatic chk(input bit ok, input string req, input logic [31:0] act,
                      input logic [31:0] exp);
      checks++;
      if (!ok) begin
         errors++;
         $display("FAIL %s: act=%h exp=%h", req, act, exp);
      end
   endtask

   task automatic chk_log(input int i, input logic [1:0] k, input logic [7:0] v,
                          input string req);
      chk(i < nlog && logk[i] == k && logv[i] == v, req,
          {22'd0, logk[i], logv[i]}, {22'd0, k, v});
   endtask

   bit got_done, got_err, got_tout;

   task automatic start_op(input logic [2:0] op, input logic [1:0] bank,
                           input logic [23:0] page, input bit spare,
                           input logic [11:0] cnt, input bit poll);
      @(negedge clk);
      nlog = 0; nrd = 0; wr_idx = 0; got_done = 0; got_err = 0; got_tout = 0;
      req_op = op; req_bank = bank; req_page = page; req_spare = spare;
      req_cnt = cnt; req_poll = poll; req_valid = 1;
      @(negedge clk);
      req_valid = 0;
   endtask

   task automatic wait_op();
      for (int i = 0; i < 20000; i++) begin
         if (done || err) begin
            got_done = done; got_err = err; got_tout = tout;
            @(negedge clk);
            return;
         end
         @(negedge clk);
      end
      chk(0, "watchdog op", 0, 1);
   endtask

   task automatic t_reset_state();
      chk(!busy && !done && !err && !tout, "R1 idle flags", {busy, done, err, tout}, 0);
      chk(nf_ce == 0 && nf_we_n && nf_re_n, "R1 bus quiet", {nf_ce, nf_we_n, nf_re_n}, 3);
   endtask

   task automatic t_chip_reset();
      bit early = 0;
      nf_rb[2] = 0;
      start_op(3'd0, 2'd2, 0, 0, 0, 0);
      for (int i = 0; i < 60; i++) begin
         if (done || err) early = 1;
         @(negedge clk);
      end
      chk(!early, "R3 no done while busy line low", early, 0);
      nf_rb[2] = 1;
      wait_op();
      chk(got_done && !got_err, "R3 done", {got_done, got_err}, 2);
      chk(nlog == 1, "R3 one cycle", nlog, 1);
      chk_log(0, 0, 8'hFF, "R3 cmd FF");
      chk(logce[0] == 4'b0100, "R2 ce bank2", logce[0], 4'b0100);
   endtask

   task automatic t_read_id();
      start_op(3'd1, 2'd0, 0, 0, 0, 0);
      wait_op();
      chk_log(0, 0, 8'h90, "R4 cmd 90");
      chk_log(1, 1, 8'h00, "R4 addr 00");
      chk(nlog == 2, "R4 no extra cycles", nlog, 2);
      chk(id_word == 32'hA514D3EC, "R4 id packing", id_word, 32'hA514D3EC);
      chk(lastlow == 8, "R11 default width 8", lastlow, 8);
   endtask

   task automatic t_page_read(input bit spare);
      poll_busy = 2;
      start_op(3'd2, 2'd1, 24'h123456, spare, 12'd3, 0);
      wait_op();
      chk(got_done, "R5 done", got_done, 1);
      chk_log(0, 0, 8'h00, "R5 cmd 00");
      chk_log(1, 1, 8'h00, "R6 col lo");
      chk_log(2, 1, spare ? 8'h08 : 8'h00, "R6 col hi");
      chk_log(3, 1, 8'h56, "R5 page lo");
      chk_log(4, 1, 8'h34, "R5 page mid");
      chk_log(5, 1, 8'h12, "R5 page hi");
      chk_log(6, 0, 8'h30, "R5 cmd 30");
      chk_log(7, 0, 8'h70, "R7 cmd 70");
      chk_log(8, 0, 8'h00, "R7 back to read 00");
      chk(stat_reads == 3, "R7 status reads", stat_reads, 3);
      chk(nrd == 4, "R5 byte count", nrd, 4);
      for (int i = 0; i < 4; i++)
         chk(rdbuf[i] == 8'h30 + 8'(i), "R5 read data", rdbuf[i], 8'h30 + 8'(i));
      chk(logce[0] == 4'b0010, "R2 ce bank1", logce[0], 4'b0010);
   endtask

   task automatic t_program(input bit poll);
      poll_busy = 1;
      start_op(3'd3, 2'd3, 24'h00BEEF, 0, 12'd2, poll);
      wait_op();
      chk(got_done, "R8 done", got_done, 1);
      chk_log(0, 0, 8'h80, "R8 cmd 80");
      chk_log(3, 1, 8'hEF, "R8 page lo");
      for (int i = 0; i < 3; i++) chk_log(6 + i, 2, 8'hA0 + 8'(i), "R8 data");
      chk_log(9, 0, 8'h10, "R8 confirm 10");
      if (poll) begin
         chk_log(10, 0, 8'h70, "R8 poll 70");
         chk_log(11, 0, 8'h00, "R7 read mode");
         chk(nlog == 12, "R8 length poll", nlog, 12);
      end else
         chk(nlog == 10, "R8 no poll", nlog, 10);
   endtask

   task automatic t_erase();
      poll_busy = 0;
      start_op(3'd4, 2'd0, 24'h0ABCDE, 1, 0, 0);
      wait_op();
      chk(got_done, "R9 done", got_done, 1);
      chk_log(0, 0, 8'h60, "R9 cmd 60");
      chk_log(1, 1, 8'hDE, "R9 row0");
      chk_log(2, 1, 8'hBC, "R9 row1");
      chk_log(3, 1, 8'h0A, "R9 row2");
      chk_log(4, 0, 8'hD0, "R9 confirm D0");
      chk_log(5, 0, 8'h70, "R9 poll");
      chk_log(6, 0, 8'h00, "R9 read mode");
      chk(nlog == 7, "R9 length", nlog, 7);
   endtask

   task automatic t_timing();
      @(negedge clk);
      tcfg_wr = 1; tcfg_bank = 1; tcfg_pulse = 2; tcfg_hold = 1;
      @(negedge clk);
      tcfg_wr = 0;
      start_op(3'd1, 2'd1, 0, 0, 0, 0);
      wait_op();
      chk(lastlow == 3, "R11 bank1 width 3", lastlow, 3);
      start_op(3'd1, 2'd0, 0, 0, 0, 0);
      wait_op();
      chk(lastlow == 8, "R11 bank0 unchanged", lastlow, 8);
   endtask

   task automatic t_timeouts();
      nf_rb[3] = 0;
      start_op(3'd0, 2'd3, 0, 0, 0, 0);
      wait_op();
      chk(got_err && got_tout && !got_done, "R10 ready timeout",
          {got_done, got_err, got_tout}, 3);
      nf_rb[3] = 1;
      poll_forever = 1;
      start_op(3'd4, 2'd0, 24'h1, 0, 0, 0);
      wait_op();
      chk(got_err && got_tout && !got_done, "R10 poll timeout",
          {got_done, got_err, got_tout}, 3);
      poll_forever = 0;
   endtask

   task automatic t_busy_ignore();
      bit extra = 0;
      poll_busy = 0;
      start_op(3'd1, 2'd0, 0, 0, 0, 0);
      repeat (10) @(negedge clk);
      req_op = 3'd0; req_valid = 1;
      @(negedge clk);
      req_valid = 0;
      wait_op();
      for (int i = 0; i < 40; i++) begin
         if (busy) extra = 1;
         @(negedge clk);
      end
      chk(!extra && nlog == 2, "R2 request while busy ignored", {extra, nlog[7:0]}, 2);
      start_op(3'd6, 2'd0, 0, 0, 0, 0);
      wait_op();
      chk(got_err && !got_tout && nlog == 0, "R2 bad op error", {got_err, got_tout, nlog[7:0]}, 32'h200);
   endtask

   initial begin
      repeat (3) @(negedge clk);
      t_reset_state();
      rst_n = 1;
      @(negedge clk);
      t_reset_state();
      t_chip_reset();
      t_read_id();
      t_page_read(0);
      t_page_read(1);
      t_program(1);
      t_program(0);
      t_erase();
      t_timing();
      t_timeouts();
      t_busy_ignore();
      chk(oe_viol == 0, "R12 no drive during read", oe_viol, 0);
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
   end
endmodule